// File: doc/BRIEF.md
# Inter-processor interrupt command unit

This block turns a two-word software command into one outgoing inter-processor interrupt message. Software first writes the destination word, then the command word. The write of the command word launches the message. A read-only busy bit in the command word stays at 1 until the message port accepts the message. Software polls this bit before it issues the next command.

The message leaves on a valid/ready port. It carries the vector, the delivery mode, the level flag, a resolved destination ID and a target class. A two-bit shorthand in the command word picks the class: self, all processors, or all processors but the sender. When the shorthand is zero, the explicit destination ID is used. In that case the all-ones ID stands for a broadcast. Only physical destinations are handled.

A write of any value to a separate completion address produces a one-cycle completion pulse for the interrupt currently being serviced.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, `msg_valid` and `eoi_pulse` are 0, and reads of the command word and of the destination word both return 0.
- R2: The command word (offset 0x300) stores these fields. Bits 7:0 hold the vector, bits 10:8 the delivery mode, bit 14 the level flag and bits 19:18 the shorthand. Bit 12 reads as the busy flag. Every other bit reads 0, and a read of an unmapped offset returns 0.
- R3: The destination word (offset 0x310) stores the destination ID in bits 31:24. Every other bit of that word reads 0.
- R4: A write to the command word while the unit is idle raises `msg_valid` in the next cycle, and bit 12 of the command word then reads 1.
- R5: While `msg_valid` is 1 and `msg_ready` is 0, the message fields are held stable. In the cycle after a clock edge with both signals at 1, `msg_valid` is 0 and bit 12 reads 0.
- R6: While the unit is busy, writes to the command word and to the destination word are ignored. The pending message and both stored words are left unchanged.
- R7: Shorthand 1 gives class 1 (self), and `msg_dest` equals `self_id`.
- R8: Shorthand 2 gives class 2 (all), and shorthand 3 gives class 3 (all but sender). In both cases `msg_dest` is 0xFF.
- R9: Shorthand 0 with a destination other than 0xFF gives class 0 (one target), and `msg_dest` is the stored destination. Shorthand 0 with destination 0xFF gives class 2 (all) with `msg_dest` 0xFF.
- R10: A write of any data to offset 0xB0 makes `eoi_pulse` 1 for exactly the following cycle. It does not change a pending message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| self_id | input | 8 | ID of the processor this unit belongs to |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read offset |
| rd_data | output | 32 | Register read data, combinational |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Message port accepts |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level flag |
| msg_dest | output | 8 | Resolved destination ID |
| msg_class | output | 2 | Target class: 0 one, 1 self, 2 all, 3 all but sender |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt strobe |

## Verification
The bench builds the unit with its default parameters: a 12-bit offset space and 8-bit IDs and vectors. At this size, all 256 vectors can be swept. The sweep cycles every delivery mode and every shorthand, and it uses several destination IDs, among them the all-ones broadcast ID and the sender's own ID. During each command, a busy-time overwrite and a completion write are issued, and the hand-off is delayed by a variable number of cycles. This brings the ignore rule, the hold rule and the completion pulse within reach on every message.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
    localparam int VEC_W     = 8;
    localparam int MODE_W    = 3;
    localparam int ID_W      = 8;
    localparam int SH_W      = 2;
    localparam int VEC_LSB   = 0;
    localparam int MODE_LSB  = 8;
    localparam int BUSY_BIT  = 12;
    localparam int LEVEL_BIT = 14;
    localparam int SH_LSB    = 18;
    localparam int DEST_LSB  = 24;

    typedef enum logic [1:0] {
        TGT_ONE    = 2'd0,
        TGT_SELF   = 2'd1,
        TGT_ALL    = 2'd2,
        TGT_OTHERS = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] mode;
        logic              level;
        logic [SH_W-1:0]   shorthand;
        logic [ID_W-1:0]   dest;
    } cmd_t;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode #(
    parameter int ADDR_W  = 12,
    parameter int CMD_OFF = 'h300,
    parameter int DST_OFF = 'h310,
    parameter int EOI_OFF = 'h0B0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              wr_cmd,
    output logic              wr_dst,
    output logic              wr_eoi,
    output logic              rd_cmd,
    output logic              rd_dst
);
    localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_OFF);
    localparam logic [ADDR_W-1:0] DST_A = ADDR_W'(DST_OFF);
    localparam logic [ADDR_W-1:0] EOI_A = ADDR_W'(EOI_OFF);

    always_comb begin
        wr_cmd = wr_en && (wr_addr == CMD_A);
        wr_dst = wr_en && (wr_addr == DST_A);
        wr_eoi = wr_en && (wr_addr == EOI_A);
        rd_cmd = (rd_addr == CMD_A);
        rd_dst = (rd_addr == DST_A);
    end
endmodule

// File: rtl/ipi_cmd_store.sv
module ipi_cmd_store
    import ipi_cmd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_dst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              fire,
    output cmd_t              cmd_q,
    output logic              busy_q
);
    typedef struct packed {
        cmd_t cmd;
        logic busy;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.busy = 1'b0;
        end
        if (!st_q.busy) begin
            if (wr_dst) begin
                st_d.cmd.dest = wr_data[DEST_LSB +: ID_W];
            end
            if (wr_cmd) begin
                st_d.cmd.vector    = wr_data[VEC_LSB +: VEC_W];
                st_d.cmd.mode      = wr_data[MODE_LSB +: MODE_W];
                st_d.cmd.level     = wr_data[LEVEL_BIT];
                st_d.cmd.shorthand = wr_data[SH_LSB +: SH_W];
                st_d.busy          = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_q  = st_q.cmd;
    assign busy_q = st_q.busy;

    // R4: an idle command write makes the unit busy
    a_r4_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && wr_cmd) |=> busy_q);

    // R5: the busy state and the command are held until acceptance
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fire) |=> (busy_q && $stable(cmd_q)));

    // R5: acceptance frees the unit
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !busy_q);

    // R6: writes during busy leave the stored words alone
    a_r6_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (wr_cmd || wr_dst)) |=> $stable(cmd_q));
endmodule

// File: rtl/ipi_target_resolve.sv
module ipi_target_resolve
    import ipi_cmd_pkg::*;
(
    input  cmd_t            cmd,
    input  logic [ID_W-1:0] self_id,
    output tgt_e            tgt,
    output logic [ID_W-1:0] dest
);
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    always_comb begin
        unique case (cmd.shorthand)
            2'd1: begin
                tgt  = TGT_SELF;
                dest = self_id;
            end
            2'd2: begin
                tgt  = TGT_ALL;
                dest = BCAST;
            end
            2'd3: begin
                tgt  = TGT_OTHERS;
                dest = BCAST;
            end
            default: begin
                tgt  = (cmd.dest == BCAST) ? TGT_ALL : TGT_ONE;
                dest = cmd.dest;
            end
        endcase
    end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
    import ipi_cmd_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int CMD_OFF = 'h300,
    parameter int DST_OFF = 'h310,
    parameter int EOI_OFF = 'h0B0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   self_id,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [VEC_W-1:0]  msg_vector,
    output logic [MODE_W-1:0] msg_mode,
    output logic              msg_level,
    output logic [ID_W-1:0]   msg_dest,
    output logic [1:0]        msg_class,
    output logic              eoi_pulse
);
    logic wr_cmd, wr_dst, wr_eoi, rd_cmd, rd_dst;
    logic fire, busy_q;
    cmd_t cmd_q;
    tgt_e tgt;

    typedef struct packed {
        logic eoi;
    } top_t;

    top_t top_d, top_q;

    ipi_addr_decode #(
        .ADDR_W (ADDR_W),
        .CMD_OFF(CMD_OFF),
        .DST_OFF(DST_OFF),
        .EOI_OFF(EOI_OFF)
    ) u_dec (
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .rd_addr(rd_addr),
        .wr_cmd (wr_cmd),
        .wr_dst (wr_dst),
        .wr_eoi (wr_eoi),
        .rd_cmd (rd_cmd),
        .rd_dst (rd_dst)
    );

    assign fire = busy_q && msg_ready;

    ipi_cmd_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cmd (wr_cmd),
        .wr_dst (wr_dst),
        .wr_data(wr_data),
        .fire   (fire),
        .cmd_q  (cmd_q),
        .busy_q (busy_q)
    );

    ipi_target_resolve u_res (
        .cmd    (cmd_q),
        .self_id(self_id),
        .tgt    (tgt),
        .dest   (msg_dest)
    );

    always_comb begin
        top_d     = top_q;
        top_d.eoi = wr_eoi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_cmd) begin
            rd_data[VEC_LSB +: VEC_W]   = cmd_q.vector;
            rd_data[MODE_LSB +: MODE_W] = cmd_q.mode;
            rd_data[BUSY_BIT]           = busy_q;
            rd_data[LEVEL_BIT]          = cmd_q.level;
            rd_data[SH_LSB +: SH_W]     = cmd_q.shorthand;
        end else if (rd_dst) begin
            rd_data[DEST_LSB +: ID_W]   = cmd_q.dest;
        end
    end

    assign msg_valid  = busy_q;
    assign msg_vector = cmd_q.vector;
    assign msg_mode   = cmd_q.mode;
    assign msg_level  = cmd_q.level;
    assign msg_class  = tgt;
    assign eoi_pulse  = top_q.eoi;

    // R10: the completion pulse follows a completion write by one cycle
    a_r10_eoi_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eoi |=> eoi_pulse);

    // R10: the completion pulse lasts a single cycle unless rewritten
    a_r10_eoi_single: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_pulse && !wr_eoi) |=> !eoi_pulse);

    // R5: the message fields stay put while the port stalls
    a_r5_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector)
            && $stable(msg_mode) && $stable(msg_class)));

    // R7: a self-targeted message names the sender
    a_r7_self_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_class == 2'd1) |-> (msg_dest == self_id));
endmodule

// File: tb/ipi_cmd_unit_bench.sv
module ipi_cmd_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  self_id = 8'h00;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        msg_valid, msg_ready, msg_level, eoi_pulse;
    logic [7:0]  msg_vector, msg_dest;
    logic [2:0]  msg_mode;
    logic [1:0]  msg_class;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ipi_cmd_unit u_ipi_cmd_unit (
        .clk(clk), .rst_n(rst_n), .self_id(self_id),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_level(msg_level),
        .msg_dest(msg_dest), .msg_class(msg_class), .eoi_pulse(eoi_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        logic [31:0] r;
        msg_ready = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rd(12'h300, r); chk("R1 cmd word", r, 32'h0);
        rd(12'h310, r); chk("R1 dst word", r, 32'h0);
        chk("R1 valid", {31'b0, msg_valid}, 32'h0);
        chk("R1 eoi", {31'b0, eoi_pulse}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(12'h300, r); chk("R1 cmd after release", r, 32'h0);

        for (int v = 0; v < 256; v++) begin
            logic [7:0]  dst, edst;
            logic [1:0]  sh, ecls;
            logic [2:0]  md;
            logic        lv;
            logic [31:0] cmd, ecmd;
            case (v % 5)
                0: dst = 8'hFF;
                1: dst = 8'h00;
                2: dst = 8'(v * 7 + 3);
                3: dst = 8'(v);
                default: dst = 8'h5A;
            endcase
            if (dst == 8'hFF && (v % 5) != 0) dst = 8'hFE;
            self_id = 8'(v ^ 8'h3C);
            if ((v % 5) == 3) self_id = dst;
            sh = 2'(v / 3);
            md = 3'(v);
            lv = v[1];
            cmd = {12'hFFF, sh, 3'b111, lv, 1'b1, 1'b1, 1'b1, md, 8'(v)};
            ecmd = {12'h0, sh, 3'b000, lv, 1'b0, 1'b1, 1'b0, md, 8'(v)};
            if (sh == 2'd1) begin ecls = 2'd1; edst = self_id; end
            else if (sh == 2'd2) begin ecls = 2'd2; edst = 8'hFF; end
            else if (sh == 2'd3) begin ecls = 2'd3; edst = 8'hFF; end
            else if (dst == 8'hFF) begin ecls = 2'd2; edst = 8'hFF; end
            else begin ecls = 2'd0; edst = dst; end

            wr(12'h310, {dst, 24'hABCDEF});
            rd(12'h310, r); chk("R3 dst readback", r, {dst, 24'h0});
            wr(12'h300, cmd);
            chk("R4 valid raised", {31'b0, msg_valid}, 32'h1);
            rd(12'h300, r); chk("R2 R4 cmd readback busy", r, ecmd);
            chk("R2 vector", {24'b0, msg_vector}, {24'b0, 8'(v)});
            chk("R2 mode", {29'b0, msg_mode}, {29'b0, md});
            chk("R2 level", {31'b0, msg_level}, {31'b0, lv});
            if (sh == 2'd1)
                chk("R7 self", {22'b0, msg_class, msg_dest}, {22'b0, ecls, edst});
            else if (sh != 2'd0)
                chk("R8 broadcast", {22'b0, msg_class, msg_dest}, {22'b0, ecls, edst});
            else
                chk("R9 explicit", {22'b0, msg_class, msg_dest}, {22'b0, ecls, edst});

            wr(12'h310, {~dst, 24'h0});
            wr(12'h300, ~cmd);
            rd(12'h310, r); chk("R6 dst kept", r, {dst, 24'h0});
            rd(12'h300, r); chk("R6 cmd kept", r, ecmd);
            chk("R6 msg kept", {14'b0, msg_class, msg_dest, msg_vector},
                {14'b0, ecls, edst, 8'(v)});

            wr(12'h0B0, 32'(v * 13));
            chk("R10 eoi pulse", {31'b0, eoi_pulse}, 32'h1);
            chk("R10 msg untouched", {31'b0, msg_valid}, 32'h1);
            @(posedge clk); #1;
            chk("R10 eoi single", {31'b0, eoi_pulse}, 32'h0);

            repeat (v % 4) @(posedge clk);
            #1;
            chk("R5 held", {23'b0, msg_valid, msg_vector}, {23'b0, 1'b1, 8'(v)});
            @(negedge clk); msg_ready = 1'b1;
            @(posedge clk); #1;
            msg_ready = 1'b0;
            chk("R5 released", {31'b0, msg_valid}, 32'h0);
            rd(12'h300, r); chk("R5 busy cleared", r, ecmd & ~32'h1000);
        end

        rd(12'h200, r); chk("R2 unmapped read", r, 32'h0);
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule